// File: doc/BRIEF.md
# UART Guard-Time and Receive Time-Out Controller

This block works next to a UART transmit shifter and a receive FIFO. On the transmit side it holds off the next word until a programmable number of baud ticks has passed since the previous word finished. It shows the result on a transmit-permit line, which the shifter samples before it starts a word. On the receive side it counts baud ticks while data waits in the FIFO and nothing new arrives. When the count reaches a programmed compare value, it sets a sticky time-out flag. The flag drives an interrupt line when the interrupt enable is high.

Both counters advance only on the single-cycle baud tick, never on the plain system clock. The guard counter is cleared when a word starts, and it begins counting only after that word completes. The time-out counter is cleared by every newly pushed word and by the FIFO going empty. It stops at the compare value, so one idle stretch yields exactly one event. Software programs the block through a single 32-bit timing register that holds the guard value, the time-out enable and the time-out compare value.

Top module: `guard_timeout_ctrl`

## Requirements
- R1: After reset the timing register reads 0, txPermit is 1, and tmoFlag and tmoIrq are 0.
- R2: A write stores bits 15:8 as the guard value, bit 7 as the time-out enable and bits 6:0 as the time-out compare value, and the register reads these fields back at the same positions. Bits 31:16 ignore writes and always read as 0.
- R3: txPermit is 0 from the cycle after txStart until the cycle after txDone. Baud ticks during the word do not advance the guard count.
- R4: With guard value G>0, after txDone txPermit rises in the cycle following the G-th baud tick counted after txDone, and it stays 0 before that tick.
- R5: With guard value 0, txPermit returns to 1 in the cycle after txDone.
- R6: With the enable at 1 and the FIFO non-empty, tmoFlag rises in the cycle after the C-th baud tick following the last push, for a compare value C of 1 or more. A compare value of 0 never raises the flag.
- R7: A push into the FIFO restarts the time-out count from zero.
- R8: While rxEmpty is 1 the time-out counter is held at zero. After the FIFO fills again, counting starts over from zero.
- R9: With the time-out enable at 0, no number of baud ticks sets tmoFlag.
- R10: tmoIrq is 1 exactly when tmoFlag is 1 and irqEn is 1.
- R11: tmoFlag stays set until a flagClr strobe clears it. A time-out event in the same cycle as flagClr leaves the flag set.
- R12: After an event the time-out counter holds at the compare value. Further baud ticks without a new push or an empty FIFO raise no second event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | Single-cycle baud-rate tick |
| regWrEn | input | 1 | Write strobe for the timing register |
| regWrData | input | 32 | Write data for the timing register |
| regRdData | output | 32 | Current timing register contents |
| txStart | input | 1 | Transmit shifter begins a word |
| txDone | input | 1 | Transmit shifter finished a word |
| txPermit | output | 1 | Next word may start |
| rxPush | input | 1 | A word was written into the RX FIFO |
| rxEmpty | input | 1 | RX FIFO is empty |
| flagClr | input | 1 | Write-one-to-clear strobe for the time-out flag |
| irqEn | input | 1 | Time-out interrupt enable |
| tmoFlag | output | 1 | Sticky time-out flag |
| tmoIrq | output | 1 | Time-out interrupt request |

## Verification
The properties assume that txStart arrives only while txPermit is high and never in the same cycle as txDone. They also assume that rxPush comes with rxEmpty low, and that baudTick is a single-cycle pulse. The bench keeps to this by issuing every strobe from its own task for one cycle. It holds baudTick low for a cycle between ticks and drops rxEmpty together with the first push. The same-cycle case of a tick that completes a time-out and a flag clear is driven deliberately, because R11 defines its outcome.

// File: rtl/gtc_pkg.sv
`timescale 1ns/1ps
package gtc_pkg;
  // Strobes sent from the control block to the counter datapath each cycle.
  typedef struct packed {
    logic guardClr;   // restart guard count (a word began)
    logic guardStep;  // baud tick while no word is in flight
    logic tmoClr;     // hold time-out count at zero
    logic tmoStep;    // baud tick for the time-out counter
  } gtcStrobe_t;
endpackage

// File: rtl/gtc_datapath.sv
`timescale 1ns/1ps
module gtc_datapath
  import gtc_pkg::*;
#(
  parameter int GUARD_W = 8,
  parameter int TMO_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  gtcStrobe_t         strb,
  input  logic [GUARD_W-1:0] guardVal,
  input  logic [TMO_W-1:0]   tmoCmp,
  output logic               guardMet,
  output logic               tmoEvent
);
  localparam logic [GUARD_W-1:0] GUARD_ONE = GUARD_W'(1);
  localparam logic [TMO_W-1:0]   TMO_ONE   = TMO_W'(1);

  logic [GUARD_W-1:0] guardCnt;
  logic [TMO_W-1:0]   tmoCnt;
  logic               guardBelow;
  logic               tmoBelow;
  logic [TMO_W-1:0]   tmoNext;

  assign guardBelow = guardCnt < guardVal;
  assign tmoBelow   = tmoCnt < tmoCmp;
  assign tmoNext    = tmoCnt + TMO_ONE;

  // Guard counter: saturates at the programmed gap.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      guardCnt <= '0;
    end else if (strb.guardClr) begin
      guardCnt <= '0;
    end else if (strb.guardStep && guardBelow) begin
      guardCnt <= guardCnt + GUARD_ONE;
    end
  end

  assign guardMet = !guardBelow;

  // Time-out counter: saturates at the compare value, never wraps.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmoCnt <= '0;
    end else if (strb.tmoClr) begin
      tmoCnt <= '0;
    end else if (strb.tmoStep && tmoBelow) begin
      tmoCnt <= tmoNext;
    end
  end

  // One event on the tick that brings the count up to the compare value.
  assign tmoEvent = !strb.tmoClr && strb.tmoStep && tmoBelow && (tmoNext == tmoCmp);
endmodule

// File: rtl/gtc_ctrl.sv
`timescale 1ns/1ps
module gtc_ctrl
  import gtc_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int GUARD_W = 8,
  parameter int TMO_W   = 7,
  localparam int EN_BIT    = TMO_W,
  localparam int GUARD_LSB = TMO_W + 1,
  localparam int USED_W    = GUARD_LSB + GUARD_W,
  localparam int GUARD_MSB = USED_W - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baudTick,
  input  logic               regWrEn,
  input  logic [USED_W-1:0]  regWrField,
  input  logic               txStart,
  input  logic               txDone,
  input  logic               rxPush,
  input  logic               rxEmpty,
  input  logic               flagClr,
  input  logic               irqEn,
  input  logic               guardMet,
  input  logic               tmoEvent,
  output gtcStrobe_t         strb,
  output logic [GUARD_W-1:0] guardVal,
  output logic [TMO_W-1:0]   tmoCmp,
  output logic [REG_W-1:0]   regRdData,
  output logic               txPermit,
  output logic               tmoFlag,
  output logic               tmoIrq
);
  logic tmoEn;
  logic sending;
  logic fresh;

  // Timing register fields; unused upper bits have no storage.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      guardVal <= '0;
      tmoEn    <= 1'b0;
      tmoCmp   <= '0;
    end else if (regWrEn) begin
      guardVal <= regWrField[GUARD_MSB:GUARD_LSB];
      tmoEn    <= regWrField[EN_BIT];
      tmoCmp   <= regWrField[TMO_W-1:0];
    end
  end

  always_comb begin
    regRdData                      = '0;
    regRdData[GUARD_MSB:GUARD_LSB] = guardVal;
    regRdData[EN_BIT]              = tmoEn;
    regRdData[TMO_W-1:0]           = tmoCmp;
  end

  // Word-in-flight tracking; fresh covers the time before any word.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sending <= 1'b0;
      fresh   <= 1'b1;
    end else if (txStart) begin
      sending <= 1'b1;
      fresh   <= 1'b0;
    end else if (txDone) begin
      sending <= 1'b0;
    end
  end

  always_comb begin
    strb.guardClr  = txStart;
    strb.guardStep = baudTick && !sending;
    strb.tmoClr    = !tmoEn || rxEmpty || rxPush;
    strb.tmoStep   = baudTick;
  end

  assign txPermit = !sending && (fresh || guardMet);

  // Sticky flag: a new event beats a simultaneous clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmoFlag <= 1'b0;
    end else if (tmoEvent) begin
      tmoFlag <= 1'b1;
    end else if (flagClr) begin
      tmoFlag <= 1'b0;
    end
  end

  assign tmoIrq = tmoFlag && irqEn;
endmodule

// File: rtl/guard_timeout_ctrl.sv
`timescale 1ns/1ps
module guard_timeout_ctrl
  import gtc_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int GUARD_W = 8,
  parameter int TMO_W   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             txStart,
  input  logic             txDone,
  output logic             txPermit,
  input  logic             rxPush,
  input  logic             rxEmpty,
  input  logic             flagClr,
  input  logic             irqEn,
  output logic             tmoFlag,
  output logic             tmoIrq
);
  localparam int USED_W = GUARD_W + TMO_W + 1;

  gtcStrobe_t         strb;
  logic [GUARD_W-1:0] guardVal;
  logic [TMO_W-1:0]   tmoCmp;
  logic               guardMet;
  logic               tmoEvent;

  gtc_ctrl #(.REG_W(REG_W), .GUARD_W(GUARD_W), .TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .regWrEn(regWrEn), .regWrField(regWrData[USED_W-1:0]),
    .txStart(txStart), .txDone(txDone),
    .rxPush(rxPush), .rxEmpty(rxEmpty),
    .flagClr(flagClr), .irqEn(irqEn),
    .guardMet(guardMet), .tmoEvent(tmoEvent),
    .strb(strb), .guardVal(guardVal), .tmoCmp(tmoCmp),
    .regRdData(regRdData), .txPermit(txPermit),
    .tmoFlag(tmoFlag), .tmoIrq(tmoIrq)
  );

  gtc_datapath #(.GUARD_W(GUARD_W), .TMO_W(TMO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .guardVal(guardVal), .tmoCmp(tmoCmp),
    .guardMet(guardMet), .tmoEvent(tmoEvent)
  );
endmodule

// File: rtl/guard_timeout_ctrl_chk.sv
`timescale 1ns/1ps
module guard_timeout_ctrl_chk #(
  parameter int REG_W   = 32,
  parameter int GUARD_W = 8,
  parameter int TMO_W   = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             txStart,
  input logic             txPermit,
  input logic             rxEmpty,
  input logic             flagClr,
  input logic             irqEn,
  input logic             tmoFlag,
  input logic             tmoIrq
);
  localparam int USED_W = GUARD_W + TMO_W + 1;
  localparam logic [REG_W-1:0] USED_MASK = {{(REG_W-USED_W){1'b0}}, {USED_W{1'b1}}};

  // R2
  reg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData == ($past(regWrData) & USED_MASK));

  // R3
  permit_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txPermit);

  // R8
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxEmpty |=> !$rose(tmoFlag));

  // R9
  tmo_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[TMO_W] |=> !$rose(tmoFlag));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !tmoIrq);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tmoFlag && !flagClr) |=> tmoFlag);
endmodule

bind guard_timeout_ctrl guard_timeout_ctrl_chk #(.REG_W(REG_W), .GUARD_W(GUARD_W), .TMO_W(TMO_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .txStart(txStart), .txPermit(txPermit),
  .rxEmpty(rxEmpty), .flagClr(flagClr), .irqEn(irqEn),
  .tmoFlag(tmoFlag), .tmoIrq(tmoIrq)
);

// File: tb/guard_timeout_ctrl_bench.sv
`timescale 1ns/100ps
module guard_timeout_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baudTick = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        txStart = 1'b0;
  logic        txDone = 1'b0;
  logic        txPermit;
  logic        rxPush = 1'b0;
  logic        rxEmpty = 1'b1;
  logic        flagClr = 1'b0;
  logic        irqEn = 1'b0;
  logic        tmoFlag;
  logic        tmoIrq;

  int totalCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  localparam int SEL_PERMIT = 0, SEL_FLAG = 1, SEL_IRQ = 2, SEL_REG = 3;

  string       tagQ[$];
  int          selQ[$];
  logic [31:0] expQ[$];

  always #2.5 clk = ~clk;

  guard_timeout_ctrl u_guard_timeout_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .txStart(txStart), .txDone(txDone), .txPermit(txPermit),
    .rxPush(rxPush), .rxEmpty(rxEmpty), .flagClr(flagClr), .irqEn(irqEn),
    .tmoFlag(tmoFlag), .tmoIrq(tmoIrq)
  );

  // Monitor: pops expected items and compares away from the active edge.
  string       mTag;
  int          mSel;
  logic [31:0] mExp;
  logic [31:0] mAct;
  always @(negedge clk) begin
    while (selQ.size() > 0) begin
      mTag = tagQ.pop_front();
      mSel = selQ.pop_front();
      mExp = expQ.pop_front();
      case (mSel)
        SEL_PERMIT: mAct = {31'b0, txPermit};
        SEL_FLAG:   mAct = {31'b0, tmoFlag};
        SEL_IRQ:    mAct = {31'b0, tmoIrq};
        default:    mAct = regRdData;
      endcase
      totalCnt++;
      if (mAct !== mExp) begin
        failCnt++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", mTag, mSel, mAct, mExp);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // Driver side of the scoreboard: queue an expectation, let the monitor take it.
  task automatic chkOut(string tag, int sel, logic [31:0] v);
    tagQ.push_back(tag); selQ.push_back(sel); expQ.push_back(v);
    @(negedge clk); #0.5;
  endtask

  task automatic tick();
    baudTick = 1'b1; cyc(1); baudTick = 1'b0; cyc(1);
  endtask

  task automatic ticks(int n);
    repeat (n) tick();
  endtask

  task automatic wrReg(logic [31:0] d);
    regWrData = d; regWrEn = 1'b1; cyc(1); regWrEn = 1'b0;
  endtask

  task automatic pushWord();
    rxPush = 1'b1; rxEmpty = 1'b0; cyc(1); rxPush = 1'b0;
  endtask

  task automatic pulseStart(); txStart = 1'b1; cyc(1); txStart = 1'b0; endtask
  task automatic pulseDone();  txDone  = 1'b1; cyc(1); txDone  = 1'b0; endtask
  task automatic pulseClr();   flagClr = 1'b1; cyc(1); flagClr = 1'b0; endtask

  task automatic summary();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      totalCnt++; failCnt++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(4);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    chkOut("R1", SEL_REG, 32'h0);
    chkOut("R1", SEL_PERMIT, 1);
    chkOut("R1", SEL_FLAG, 0);
    chkOut("R1", SEL_IRQ, 0);

    // R2 field layout; upper bits ignored
    wrReg(32'hFFFF_A5C3);
    chkOut("R2", SEL_REG, 32'h0000_A5C3);
    wrReg(32'h1234_0300);
    chkOut("R2", SEL_REG, 32'h0000_0300);

    // R3 / R4 guard of 3 ticks
    chkOut("R4", SEL_PERMIT, 1);
    pulseStart();
    chkOut("R3", SEL_PERMIT, 0);
    ticks(4);
    chkOut("R3", SEL_PERMIT, 0);
    pulseDone();
    chkOut("R4", SEL_PERMIT, 0);
    ticks(2);
    chkOut("R4", SEL_PERMIT, 0);
    tick();
    chkOut("R4", SEL_PERMIT, 1);

    // R5 zero guard
    wrReg(32'h0000_0000);
    pulseStart();
    chkOut("R5", SEL_PERMIT, 0);
    pulseDone();
    chkOut("R5", SEL_PERMIT, 1);

    // R6 / R10 / R11 / R12 time-out with compare 4
    wrReg(32'h0000_0084);
    pushWord();
    ticks(3);
    chkOut("R6", SEL_FLAG, 0);
    tick();
    chkOut("R6", SEL_FLAG, 1);
    chkOut("R10", SEL_IRQ, 0);
    irqEn = 1'b1;
    chkOut("R10", SEL_IRQ, 1);
    cyc(3);
    chkOut("R11", SEL_FLAG, 1);
    pulseClr();
    chkOut("R11", SEL_FLAG, 0);
    chkOut("R10", SEL_IRQ, 0);
    ticks(200);
    chkOut("R12", SEL_FLAG, 0);

    // R7 push restarts the count
    pushWord();
    ticks(3);
    pushWord();
    ticks(3);
    chkOut("R7", SEL_FLAG, 0);
    tick();
    chkOut("R7", SEL_FLAG, 1);
    pulseClr();

    // R8 empty FIFO holds the counter at zero
    pushWord();
    ticks(2);
    rxEmpty = 1'b1;
    ticks(6);
    chkOut("R8", SEL_FLAG, 0);
    pushWord();
    ticks(3);
    chkOut("R8", SEL_FLAG, 0);
    tick();
    chkOut("R8", SEL_FLAG, 1);
    pulseClr();

    // R9 enable off
    wrReg(32'h0000_0004);
    chkOut("R9", SEL_REG, 32'h0000_0004);
    pushWord();
    ticks(10);
    chkOut("R9", SEL_FLAG, 0);

    // R11 event beats simultaneous clear (compare 2)
    wrReg(32'h0000_0082);
    pushWord();
    ticks(2);
    chkOut("R11", SEL_FLAG, 1);
    pushWord();
    tick();
    baudTick = 1'b1; flagClr = 1'b1; cyc(1);
    baudTick = 1'b0; flagClr = 1'b0; cyc(1);
    chkOut("R11", SEL_FLAG, 1);
    pulseClr();
    chkOut("R11", SEL_FLAG, 0);

    // R6 compare 0 never fires
    wrReg(32'h0000_0080);
    pushWord();
    ticks(5);
    chkOut("R6", SEL_FLAG, 0);

    cyc(2);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule